// File: doc/BRIEF.md
# Key-Protected Interrupt and Reset Control Register

This block is one 32-bit control register that sits in front of a processor's interrupt and reset logic. It is reached over a plain register bus: an address, a write enable, 32 bits of write data and 32 bits of registered read data. Software uses it to pick how an 8-bit interrupt priority is split between pre-emption and sub-priority. It also uses it to fire three one-shot commands: a system reset request, a local core reset and a clear of all active exception state.

A write takes effect only when its upper halfword carries the unlock key 0x05FA. Any other write is dropped as a whole. Reads return a fixed signature in the upper halfword, the endianness flag taken from a static configuration input, and the stored grouping field. The command bits are not state: an accepted write turns each one into a single-cycle pulse, and they always read as zero.

The block also drives the pre-emption mask for the current grouping value, so a priority comparator downstream can use it without decoding the field again.

Top module: `keyed_irq_rst_ctl`

## Requirements
- R1: A write whose data bits 31:16 differ from 0x05FA leaves the grouping field unchanged and produces no command pulse, even when command bits 2:0 are set.
- R2: Read data bits 31:16 are 0xFA05 whenever the register address is read, whatever was last written there.
- R3: The grouping field is stored from write data bits 10:8 on an accepted write, reads back in bits 10:8, and is 000 after reset.
- R4: An accepted write with bit 2 set drives `sys_reset_req_o` high for exactly the cycle after the write edge. An accepted write with bit 2 clear leaves it low.
- R5: An accepted write with bit 1 set drives `clr_active_o` high for one cycle. Read data bits 2:0 are always 0.
- R6: An accepted write with bit 0 set drives `core_reset_o` high for one cycle.
- R7: Read bit 15 reflects `big_endian_i` as registered on the previous edge and cannot be written. Read bits 14:11 and 7:3 are always 0.
- R8: `preempt_mask_o` bit i is 1 exactly when i is greater than the grouping value: 0xFE for 000, down to 0x00 for 111.
- R9: Read data is registered. It shows the register image one cycle after the address matches and 0 otherwise. A write to any other address has no effect.
- R10: During and right after reset, all pulse outputs and read data are 0 and the mask is 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 12 | Register bus address |
| wr_en_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| big_endian_i | input | 1 | Static endianness configuration, 1 = big-endian |
| rdata_o | output | 32 | Registered read data |
| sys_reset_req_o | output | 1 | System reset request pulse |
| core_reset_o | output | 1 | Local core reset pulse |
| clr_active_o | output | 1 | Clear-active-exception-state pulse |
| preempt_mask_o | output | 8 | Pre-emption mask for the current grouping |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, a 16-bit key, an 8-bit priority and a 3-bit grouping field at address 0x00C. With these values all eight grouping codes can be walked in turn, so every mask from 0xFE down to 0x00 is reached. The default address also leaves room to aim a correctly keyed write at a neighbouring address. Back-to-back operations show that a command pulse drops in the very next cycle, and they also cover keys that are off by one or that match the read signature instead of the write key.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  // command bit positions inside the write data (decoded by the reset logic)
  localparam int CMD_W      = 3;
  localparam int CMD_CORE   = 0;
  localparam int CMD_CLRACT = 1;
  localparam int CMD_SYSREQ = 2;
  // field positions
  localparam int GRP_LSB    = 8;
  localparam int ENDIAN_BIT = 15;
endpackage

// File: rtl/rcr_key_decode.sv
module rcr_key_decode #(
  parameter int ADDR_W   = 12,
  parameter int KEY_W    = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter logic [KEY_W-1:0]  WR_KEY   = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              hit_o,
  output logic              accept_o
);
  always_comb begin
    hit_o    = (addr_i == REG_ADDR);
    accept_o = hit_o && wr_en_i && (key_i == WR_KEY);
  end
endmodule

// File: rtl/rcr_group_field.sv
module rcr_group_field #(
  parameter int GRP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic [GRP_W-1:0] wgrp_i,
  output logic [GRP_W-1:0] grp_o
);
  logic [GRP_W-1:0] grp_q;

  always_ff @(posedge clk) begin
    if (rst)           grp_q <= '0;
    else if (accept_i) grp_q <= wgrp_i;
  end

  assign grp_o = grp_q;

  // R1
  grp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(accept_i) |-> $stable(grp_q));
endmodule

// File: rtl/rcr_prio_mask.sv
module rcr_prio_mask #(
  parameter int GRP_W  = 3,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GRP_W-1:0]  grp_i,
  output logic [PRIO_W-1:0] mask_o
);
  for (genvar gi = 0; gi < PRIO_W; gi++) begin : g_bit
    assign mask_o[gi] = (gi > int'(grp_i));
  end

  // R8
  mask_width_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(mask_o) == ((PRIO_W - 1 - int'(grp_i)) > 0 ? (PRIO_W - 1 - int'(grp_i)) : 0));
endmodule

// File: rtl/rcr_cmd_pulse.sv
module rcr_cmd_pulse #(
  parameter int CMD_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic [CMD_W-1:0] pulse_o
);
  for (genvar ci = 0; ci < CMD_W; ci++) begin : g_cmd
    logic p_q;
    always_ff @(posedge clk) begin
      if (rst) p_q <= 1'b0;
      else     p_q <= accept_i & cmd_i[ci];
    end
    assign pulse_o[ci] = p_q;

    // R1
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
      p_q |-> $past(accept_i));
  end
endmodule

// File: rtl/keyed_irq_rst_ctl.sv
module keyed_irq_rst_ctl
  import rcr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int KEY_W  = 16,
  parameter int GRP_W  = 3,
  parameter int PRIO_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h00C,
  parameter logic [KEY_W-1:0]  WR_KEY   = 16'h05FA,
  parameter logic [KEY_W-1:0]  RD_SIG   = 16'hFA05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              big_endian_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sys_reset_req_o,
  output logic              core_reset_o,
  output logic              clr_active_o,
  output logic [PRIO_W-1:0] preempt_mask_o
);
  localparam int KEY_LSB = DATA_W - KEY_W;
  localparam int GRP_MSB = GRP_LSB + GRP_W - 1;

  logic             hit, accept;
  logic [GRP_W-1:0] grp;
  logic [CMD_W-1:0] pulses;
  logic             endian_q;
  logic [DATA_W-1:0] image, rdata_q;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata_i[KEY_LSB-1:GRP_MSB+1], wdata_i[GRP_LSB-1:CMD_W]};

  rcr_key_decode #(
    .ADDR_W(ADDR_W), .KEY_W(KEY_W), .REG_ADDR(REG_ADDR), .WR_KEY(WR_KEY)
  ) u_key (
    .addr_i(addr_i), .wr_en_i(wr_en_i), .key_i(wdata_i[DATA_W-1:KEY_LSB]),
    .hit_o(hit), .accept_o(accept)
  );

  rcr_group_field #(.GRP_W(GRP_W)) u_grp (
    .clk(clk), .rst(rst), .accept_i(accept),
    .wgrp_i(wdata_i[GRP_MSB:GRP_LSB]), .grp_o(grp)
  );

  rcr_prio_mask #(.GRP_W(GRP_W), .PRIO_W(PRIO_W)) u_mask (
    .clk(clk), .rst(rst), .grp_i(grp), .mask_o(preempt_mask_o)
  );

  rcr_cmd_pulse #(.CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst(rst), .accept_i(accept),
    .cmd_i(wdata_i[CMD_W-1:0]), .pulse_o(pulses)
  );

  always_ff @(posedge clk) begin
    if (rst) endian_q <= 1'b0;
    else     endian_q <= big_endian_i;
  end

  always_comb begin
    image = '0;
    image[DATA_W-1:KEY_LSB] = RD_SIG;
    image[ENDIAN_BIT]       = endian_q;
    image[GRP_MSB:GRP_LSB]  = grp;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= hit ? image : '0;
  end

  assign rdata_o         = rdata_q;
  assign sys_reset_req_o = pulses[CMD_SYSREQ];
  assign core_reset_o    = pulses[CMD_CORE];
  assign clr_active_o    = pulses[CMD_CLRACT];

  // R2
  rd_sig_chk: assert property (@(posedge clk) disable iff (rst)
    (rdata_q != '0) |-> (rdata_q[DATA_W-1:KEY_LSB] == RD_SIG));

  // R5
  rd_cmd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdata_q[CMD_W-1:0] == '0);

  // R4
  sysreq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req_o |-> $past(wr_en_i && (addr_i == REG_ADDR) &&
      (wdata_i[DATA_W-1:KEY_LSB] == WR_KEY) && wdata_i[CMD_SYSREQ]));

  // R6
  core_cause_chk: assert property (@(posedge clk) disable iff (rst)
    core_reset_o |-> $past(wr_en_i && (addr_i == REG_ADDR) &&
      (wdata_i[DATA_W-1:KEY_LSB] == WR_KEY) && wdata_i[CMD_CORE]));
endmodule

// File: tb/keyed_irq_rst_ctl_tb.sv
module keyed_irq_rst_ctl_tb;
  localparam logic [11:0] RA = 12'h00C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        big_endian = 1'b0;
  logic [31:0] rdata;
  logic        sysreq, corerst, clract;
  logic [7:0]  mask;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keyed_irq_rst_ctl u_dut (
    .clk(clk), .rst(rst), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .big_endian_i(big_endian), .rdata_o(rdata), .sys_reset_req_o(sysreq),
    .core_reset_o(corerst), .clr_active_o(clract), .preempt_mask_o(mask)
  );

  typedef struct {
    logic [31:0] rd;
    logic        s, c, a;
    logic [7:0]  m;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [2:0] m_grp = 3'd0;
  logic       m_end = 1'b0;

  function automatic logic [7:0] mask_of(input logic [2:0] g);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (i > int'(g));
    return r;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: one bus cycle, expected result pushed after the edge
  task automatic op(input logic [11:0] a, input logic we, input logic [31:0] wd, input string tag);
    exp_t e;
    logic acc;
    @(negedge clk);
    addr = a; wr_en = we; wdata = wd;
    acc = we && (a == RA) && (wd[31:16] == 16'h05FA);
    e.rd = (a == RA) ? {16'hFA05, m_end, 4'b0, m_grp, 8'h00} : 32'h0;
    m_end = big_endian;
    if (acc) m_grp = wd[10:8];
    e.s = acc & wd[2];
    e.a = acc & wd[1];
    e.c = acc & wd[0];
    e.m = mask_of(m_grp);
    e.tag = tag;
    @(posedge clk);
    #1;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      check(e.tag, "rdata", rdata, e.rd);
      check(e.tag, "sys_reset_req", {31'b0, sysreq}, {31'b0, e.s});
      check(e.tag, "core_reset", {31'b0, corerst}, {31'b0, e.c});
      check(e.tag, "clr_active", {31'b0, clract}, {31'b0, e.a});
      check(e.tag, "mask", {24'b0, mask}, {24'b0, e.m});
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    vectors++;
    check("R10", "reset rdata", rdata, 32'h0);
    check("R10", "reset pulses", {29'b0, sysreq, corerst, clract}, 32'h0);
    check("R10", "reset mask", {24'b0, mask}, 32'h0000_00FE);
    rst = 1'b0;

    op(RA, 0, 32'h0, "R10 R3 R2 first read");
    op(RA, 1, 32'h05FA_0300, "R3 write grouping 3");
    op(RA, 0, 32'h0, "R3 readback");
    op(RA, 1, 32'h05FB_0507, "R1 off-by-one key");
    op(RA, 0, 32'h0, "R1 field unchanged");
    op(RA, 1, 32'hFA05_0607, "R1 R2 signature as key");
    op(RA, 0, 32'h0, "R1 R2 after signature write");
    op(RA, 1, 32'h05FA_0304, "R4 sysreq write");
    op(RA, 0, 32'h0, "R4 pulse dropped");
    op(RA, 1, 32'h05FA_0300, "R4 bit2 clear no pulse");
    op(RA, 1, 32'h05FA_0302, "R5 clear active write");
    op(RA, 0, 32'h0, "R5 read bits zero");
    op(RA, 1, 32'h05FA_0301, "R6 core reset write");
    op(RA, 1, 32'h05FA_0301, "R6 back to back");
    op(RA, 0, 32'h0, "R6 pulse dropped");
    op(12'h010, 1, 32'h05FA_0707, "R9 other address write");
    op(12'h010, 0, 32'h0, "R9 other address read");
    op(RA, 0, 32'h0, "R9 field unchanged");
    op(RA, 1, 32'h05FA_FFFF, "R7 all ones write");
    op(RA, 0, 32'h0, "R7 unused bits zero");
    for (int g = 0; g < 8; g++) begin
      op(RA, 1, 32'h05FA_0000 | (32'(g) << 8), "R8 grouping sweep");
      op(RA, 0, 32'h0, "R8 R3 sweep readback");
    end
    big_endian = 1'b1;
    op(RA, 0, 32'h0, "R7 endian sample");
    op(RA, 0, 32'h0, "R7 endian readback");
    op(RA, 1, 32'h05FA_0000, "R7 endian not writable");
    op(RA, 0, 32'h0, "R7 endian still set");
    big_endian = 1'b0;
    op(RA, 0, 32'h0, "R7 endian clear sample");
    op(RA, 0, 32'h0, "R7 endian cleared");
    op(RA, 1, 32'h0000_0507, "R1 zero key");
    op(RA, 0, 32'h0, "R1 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule